// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block merges five interrupt sources into one request line and one vector address for a processor core. The sources are two external active-low pins, two timer overflow flags and a serial flag. The serial flag is the OR of a receive flag and a transmit flag. Each source has its own enable, and a global enable gates all of them. Each source can be placed at a high or a low priority level. Inside one level, a fixed order decides between sources.

Each external pin is sampled once per machine cycle, on a `mc_tick` strobe. It is configured as either falling-edge or low-level sensitive. In edge mode, a detected falling edge is latched into a flag that stays set until that source is acknowledged. The core acknowledges a request with a one-cycle `ack` pulse and ends a service with a one-cycle `reti` pulse. The block tracks which levels are in service, so that a high-priority request can interrupt a low-priority service but never the reverse.

The `irq`/`ack` pair works as a valid/ready handshake. `irq` together with `irq_vec` and `irq_hi` forms the offer. `ack` takes it only in a cycle where `irq` is high. The offer may change before it is taken if a more urgent source appears, because there is no holding stage.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `tmr_clr` is 0, both external flags are 0, and no priority level is in service.
- R2: A source can request only when its bit in `irq_en` is 1 and `irq_gie` is 1. Bit order of `irq_en` and `pri_sel` is: bit0 external 0, bit1 timer 0, bit2 external 1, bit3 timer 1, bit4 serial.
- R3: `irq_vec` is 0x0003 + 8 × (bit index of the winning source): 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R4: Among pending sources at the same level, the lowest bit index wins.
- R5: A source with `pri_sel` bit 1 (high level) wins over any low-level source. `irq_hi` is 1 exactly when the offered source is high level.
- R6: With `ext_edge[k]`=1, a pin sampled high on one `mc_tick` and low on the next sets `ext_flag[k]`, effective after that tick's clock edge. The flag requests even after the pin returns high. It clears when that source is acknowledged.
- R7: With `ext_edge[k]`=0, an external source requests while its last `mc_tick` sample is low, and it latches nothing. A pin change without a tick has no effect.
- R8: The serial source requests when `ser_rx` or `ser_tx` is 1. Acknowledging it clears nothing.
- R9: In the cycle in which `ack` takes timer k, `tmr_clr[k]` is 1. At all other times `tmr_clr` is 0.
- R10: While a low-level service is active, only high-level sources are offered. While a high-level service is active, nothing is offered. `reti` ends the high-level service if one is active, and otherwise ends the low-level service.
- R11: `ack` while `irq` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe for pin sampling |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | Timer overflow flags |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| irq_en | input | 5 | Per-source enables |
| irq_gie | input | 1 | Global enable |
| pri_sel | input | 5 | Per-source level, 1 = high |
| ack | input | 1 | Core takes the offered request |
| reti | input | 1 | Core ends the current service |
| irq | output | 1 | Request offered |
| irq_vec | output | 16 | Vector of offered source |
| irq_hi | output | 1 | Offered source is high level |
| ext_flag | output | 2 | Latched external edge flags |
| tmr_clr | output | 2 | Timer overflow clear strobes |

## Verification
`irq`, `irq_vec` and `irq_hi` follow the source inputs and enables within the same cycle. `tmr_clr` follows `ack` within the same cycle. A pin change reaches the outputs only through the clock edge on which `mc_tick` is high. A change in service state from `ack` or `reti` shows from the cycle after the pulse. The bench drives every input on the falling clock edge and samples 1 ns later. Combinational results are therefore read in the same half cycle. Tick-, ack- and reti-driven results are read only after the rising edge that registers them has passed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int N_EXT = 2;
  localparam int IDXW  = $clog2(NSRC);
  typedef enum logic [IDXW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;
endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req,
  output logic flag
);
  logic smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp  <= 1'b1;
      flag <= 1'b0;
    end else begin
      if (tick) smp <= pin_n;
      // a new edge wins over a clear in the same cycle so no edge is lost
      if (tick && edge_mode && smp && !pin_n) flag <= 1'b1;
      else if (clr)                           flag <= 1'b0;
    end
  end

  assign req = edge_mode ? flag : !smp;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] elig,
  input  logic [NSRC-1:0] pri,
  input  logic            allow_hi,
  input  logic            allow_lo,
  output logic            valid,
  output logic [IDXW-1:0] idx,
  output logic            hi
);
  logic [NSRC-1:0] cand_hi, cand_lo;

  assign cand_hi = allow_hi ? (elig & pri)  : '0;
  assign cand_lo = allow_lo ? (elig & ~pri) : '0;

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    hi    = 1'b0;
    // scan downward so the lowest index is the last to assign
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_lo[i]) begin
        valid = 1'b1;
        idx   = IDXW'(i);
      end
    end
    if (|cand_hi) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (cand_hi[i]) idx = IDXW'(i);
      end
      valid = 1'b1;
      hi    = 1'b1;
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic allow_hi,
  output logic allow_lo
);
  logic act_hi, act_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) act_hi <= 1'b1;
      else         act_lo <= 1'b1;
    end else if (reti) begin
      if (act_hi) act_hi <= 1'b0;
      else        act_lo <= 1'b0;
    end
  end

  assign allow_hi = !act_hi;
  assign allow_lo = !act_hi && !act_lo;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int          VW       = 16,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter int          VEC_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mc_tick,
  input  logic [N_EXT-1:0]     ext_n,
  input  logic [N_EXT-1:0]     ext_edge,
  input  logic [N_EXT-1:0]     tmr_ovf,
  input  logic                 ser_rx,
  input  logic                 ser_tx,
  input  logic [NSRC-1:0]      irq_en,
  input  logic                 irq_gie,
  input  logic [NSRC-1:0]      pri_sel,
  input  logic                 ack,
  input  logic                 reti,
  output logic                 irq,
  output logic [VW-1:0]        irq_vec,
  output logic                 irq_hi,
  output logic [N_EXT-1:0]     ext_flag,
  output logic [N_EXT-1:0]     tmr_clr
);
  localparam logic [VW-1:0] BASE = VW'(VEC_BASE);
  localparam logic [VW-1:0] STEP = VW'(VEC_STEP);

  logic [NSRC-1:0]  pend, elig;
  logic [N_EXT-1:0] ext_req, ext_clr;
  logic [IDXW-1:0]  win;
  logic             allow_hi, allow_lo, take;

  assign take = ack && irq;

  for (genvar k = 0; k < N_EXT; k++) begin : g_src
    // external k sits at index 2k, timer k at 2k+1
    assign ext_clr[k] = take && (win == IDXW'(2 * k));
    assign tmr_clr[k] = take && (win == IDXW'(2 * k + 1));
    assign pend[2 * k]     = ext_req[k];
    assign pend[2 * k + 1] = tmr_ovf[k];

    irq_ext_sense u_sense (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (mc_tick),
      .pin_n     (ext_n[k]),
      .edge_mode (ext_edge[k]),
      .clr       (ext_clr[k]),
      .req       (ext_req[k]),
      .flag      (ext_flag[k])
    );
  end

  assign pend[SRC_SER] = ser_rx || ser_tx;
  assign elig = pend & irq_en & {NSRC{irq_gie}};

  irq_arbiter u_arb (
    .elig     (elig),
    .pri      (pri_sel),
    .allow_hi (allow_hi),
    .allow_lo (allow_lo),
    .valid    (irq),
    .idx      (win),
    .hi       (irq_hi)
  );

  irq_nest u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_hi  (irq_hi),
    .reti     (reti),
    .allow_hi (allow_hi),
    .allow_lo (allow_lo)
  );

  assign irq_vec = BASE + STEP * VW'(win);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        irq_hi,
  input logic [15:0] irq_vec,
  input logic        irq_gie,
  input logic        ack,
  input logic        reti,
  input logic [1:0]  tmr_clr,
  input logic [1:0]  ext_flag
);
  logic hi_busy;

  always_ff @(posedge clk) begin
    if (!rst_n)                    hi_busy <= 1'b0;
    else if (ack && irq && irq_hi) hi_busy <= 1'b1;
    else if (reti)                 hi_busy <= 1'b0;
  end

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> irq_gie); // R2
  AST_VEC_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h0023)); // R3
  AST_CLR_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_clr) |-> (ack && irq)); // R9
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tmr_clr)); // R9
  AST_HI_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) hi_busy |-> !irq); // R10
  AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flag[0] && !(ack && irq && irq_vec == 16'h0003)) |=> ext_flag[0]); // R6
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .irq_hi   (irq_hi),
  .irq_vec  (irq_vec),
  .irq_gie  (irq_gie),
  .ack      (ack),
  .reti     (reti),
  .tmr_clr  (tmr_clr),
  .ext_flag (ext_flag)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, mc_tick = 1'b0;
  logic [1:0] ext_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00;
  logic ser_rx = 1'b0, ser_tx = 1'b0, irq_gie = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [4:0] irq_en = '0, pri_sel = '0;
  logic irq, irq_hi;
  logic [15:0] irq_vec;
  logic [1:0] ext_flag, tmr_clr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ext_n(ext_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_en(irq_en),
    .irq_gie(irq_gie), .pri_sel(pri_sel), .ack(ack), .reti(reti), .irq(irq),
    .irq_vec(irq_vec), .irq_hi(irq_hi), .ext_flag(ext_flag), .tmr_clr(tmr_clr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic tick();
    @(negedge clk); mc_tick = 1'b1;
    @(negedge clk); mc_tick = 1'b0; #1;
  endtask

  task automatic pulse_ack(output logic [1:0] clr_seen);
    @(negedge clk); ack = 1'b1; #1; clr_seen = tmr_clr;
    @(negedge clk); ack = 1'b0; #1;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0; #1;
  endtask

  task automatic t_reset();
    step();
    check("R1 irq", irq, 0);
    check("R1 tmr_clr", tmr_clr, 0);
    check("R1 ext_flag", ext_flag, 0);
  endtask

  task automatic t_enables();
    tmr_ovf = 2'b01; step();
    check("R2 no enable", irq, 0);
    irq_en = 5'b00010; step();
    check("R2 no global", irq, 0);
    irq_gie = 1'b1; step();
    check("R2 enabled irq", irq, 1);
    check("R3 timer0 vec", irq_vec, 16'h000B);
    tmr_ovf = 2'b00;
  endtask

  task automatic t_order();
    irq_en = 5'b11111; tmr_ovf = 2'b11; ser_rx = 1'b1; step();
    check("R4 timer0 first", irq_vec, 16'h000B);
    tmr_ovf = 2'b10; step();
    check("R4 timer1 next", irq_vec, 16'h001B);
    tmr_ovf = 2'b00; step();
    check("R8 rx vec", irq_vec, 16'h0023);
    ser_rx = 1'b0; ser_tx = 1'b1; step();
    check("R8 tx requests", irq, 1);
    ser_tx = 1'b0; step();
    check("R8 idle", irq, 0);
  endtask

  task automatic t_priority();
    tmr_ovf = 2'b11; pri_sel = 5'b01000; step();
    check("R5 high wins vec", irq_vec, 16'h001B);
    check("R5 irq_hi", irq_hi, 1);
    pri_sel = 5'b00000; step();
    check("R5 low flag", irq_hi, 0);
    tmr_ovf = 2'b00;
  endtask

  task automatic t_edge();
    logic [1:0] c;
    ext_edge = 2'b01; ext_n[0] = 1'b1; tick();
    ext_n[0] = 1'b0; step();
    check("R6 no tick no flag", ext_flag[0], 0);
    tick();
    check("R6 flag set", ext_flag[0], 1);
    check("R3 ext0 vec", irq_vec, 16'h0003);
    ext_n[0] = 1'b1; tick();
    check("R6 flag held", irq, 1);
    pulse_ack(c);
    check("R6 flag cleared", ext_flag[0], 0);
    pulse_reti(); step();
    check("R6 no request after clear", irq, 0);
  endtask

  task automatic t_level();
    ext_edge = 2'b00; ext_n[1] = 1'b0; step();
    check("R7 no tick no req", irq, 0);
    tick();
    check("R7 level vec", irq_vec, 16'h0013);
    check("R7 nothing latched", ext_flag[1], 0);
    ext_n[1] = 1'b1; tick();
    check("R7 released", irq, 0);
  endtask

  task automatic t_timer_ack();
    logic [1:0] c;
    tmr_ovf = 2'b10; step();
    pulse_ack(c);
    check("R9 clear strobe", c, 2'b10);
    check("R9 strobe gone", tmr_clr, 2'b00);
    tmr_ovf = 2'b00;
    pulse_reti();
  endtask

  task automatic t_serial_ack();
    logic [1:0] c;
    ser_rx = 1'b1; pri_sel = 5'b10000; step();
    pulse_ack(c);
    check("R8 no timer strobe", c, 2'b00);
    pulse_reti(); step();
    check("R8 flag not cleared", irq_vec, 16'h0023);
    ser_rx = 1'b0; pri_sel = 5'b00000;
  endtask

  task automatic t_nesting();
    logic [1:0] c;
    tmr_ovf = 2'b01; step();
    pulse_ack(c);
    check("R10 same level blocked", irq, 0);
    pri_sel = 5'b01000; tmr_ovf = 2'b11; step();
    check("R10 high preempts vec", irq_vec, 16'h001B);
    pulse_ack(c);
    check("R10 high service blocks", irq, 0);
    pulse_reti();
    check("R10 high reoffered", irq_vec, 16'h001B);
    tmr_ovf = 2'b01; step();
    check("R10 low still blocked", irq, 0);
    pulse_reti();
    check("R10 low resumes", irq_vec, 16'h000B);
    tmr_ovf = 2'b00; pri_sel = 5'b00000;
  endtask

  task automatic t_ack_idle();
    logic [1:0] c;
    step();
    pulse_ack(c);
    check("R11 no strobe", c, 2'b00);
    tmr_ovf = 2'b01; step();
    check("R11 ack ignored", irq, 1);
    tmr_ovf = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enables();
    t_order();
    t_priority();
    t_edge();
    t_level();
    t_timer_ack();
    t_serial_ack();
    t_nesting();
    t_ack_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule